// File: doc/BRIEF.md
# Quadrant Spare Row and Column Repair Remapper

This block steers every access of a memory array away from defective lines. The array is split into four quadrants, and each quadrant has its own pool of spare rows and spare columns. At configuration time a repair table is filled through a small write port. Each table entry covers one spare. It holds a valid bit and the index of the defective line that the spare replaces.

On every access the block compares the quadrant, row and column of the access with the table entries of that quadrant. On a row hit the physical row becomes the number of the spare row, and the output flag for spare rows is raised. A column hit works the same way for columns. Both substitutions can apply to the same access, and the whole lookup path is combinational. The memory then reads the spare line in place of the defective one.

A small configuration monitor watches the writes. It has two states, `CFG_CLEAN` and `CFG_FAULT`. After reset it is in `CFG_CLEAN`. It takes the transition `CFG_CLEAN -> CFG_FAULT` when a write makes a second valid spare of the same kind in the same quadrant point at the same defective index. It takes the transition `CFG_FAULT -> CFG_FAULT` on every later cycle, so it stays there until reset. The output `cfg_error` is high in `CFG_FAULT`.

Top module: `rr_repair_remap`

## Requirements
- R1: After reset no spare is valid, `cfg_error` is 0, and every access passes through unchanged: `phys_row`=`acc_row`, `phys_col`=`acc_col`, and both spare flags are 0.
- R2: Take a valid row entry in quadrant q, slot s, with index equal to `acc_row`. For an access to quadrant q it gives `row_on_spare`=1 and `phys_row`=s, zero-extended.
- R3: Take a valid column entry in quadrant q, slot s, with index equal to `acc_col`. For an access to quadrant q it gives `col_on_spare`=1 and `phys_col`=s, zero-extended.
- R4: When the row and the column of one access both hit, both substitutions appear together on the same access.
- R5: An entry of one quadrant never redirects an access to another quadrant.
- R6: Writing a slot with `cfg_valid`=0 clears it, and a cleared slot never matches.
- R7: The outputs follow a change of the access address within the same clock cycle, with no clock edge in between.
- R8: A valid write whose index equals the index of another valid slot of the same kind in the same quadrant sets `cfg_error`. The flag stays at 1 until reset.
- R9: When more than one valid slot matches, the lowest-numbered slot is used.
- R10: A write whose slot number is at or above the number of spares of its kind (16 rows, 24 columns) changes nothing and cannot set `cfg_error`.
- R11: One quadrant can hold all 16 row repairs and all 24 column repairs at once, and every one of them redirects.
- R12: Writing the same slot again with the index it already holds is not a duplicate and leaves `cfg_error` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Repair table write strobe |
| cfg_quad | input | 2 | Quadrant of the written entry |
| cfg_kind | input | 1 | 0 = spare row, 1 = spare column |
| cfg_slot | input | 5 | Spare number being written |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_index | input | 8 | Defective line index to store |
| acc_quad | input | 2 | Quadrant of the access |
| acc_row | input | 8 | Logical row of the access |
| acc_col | input | 8 | Logical column of the access |
| phys_row | output | 8 | Logical row, or the spare row number on a hit |
| row_on_spare | output | 1 | The row was redirected to a spare |
| phys_col | output | 8 | Logical column, or the spare column number on a hit |
| col_on_spare | output | 1 | The column was redirected to a spare |
| cfg_error | output | 1 | A duplicate repair entry was written |

## Verification
The lookup is tried in several situations:
- with only a row entry, only a column entry, and both at once, which separates the row path from the column path and shows whether both substitutions appear together;
- against the same address in a neighbouring quadrant, to show that quadrants are kept apart;
- against a slot that has been cleared, to show that invalid entries never match;
- against a fully populated quadrant, to show that all 16 row spares and all 24 column spares work at once;
- with an address change inside a clock cycle, to show that the path is combinational.

For the configuration monitor, an identical rewrite, an out-of-range slot and a true duplicate are written in turn, so that the error flag is told apart from an ordinary rewrite. The duplicate case also shows that the lower slot wins the lookup.

// File: rtl/rr_repair_pkg.sv
package rr_repair_pkg;

    typedef enum logic {
        CFG_CLEAN = 1'b0,
        CFG_FAULT = 1'b1
    } cfg_state_t;

    localparam logic KIND_ROW = 1'b0;
    localparam logic KIND_COL = 1'b1;

endpackage

// File: rtl/rr_first_set.sv
// Lowest-index-first priority encoder.
module rr_first_set #(
    parameter int N     = 16,
    parameter int OUT_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [OUT_W-1:0] pos
);
    always_comb begin
        any = 1'b0;
        pos = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                pos = OUT_W'(i);
            end
        end
    end
endmodule

// File: rtl/rr_spare_bank.sv
// Repair table for one kind of spare across all quadrants, with lookup
// and duplicate-write detection.
module rr_spare_bank #(
    parameter int N_QUAD  = 4,
    parameter int N_SPARE = 16,
    parameter int IDX_W   = 8,
    parameter int SLOT_W  = 5,
    localparam int QUAD_W = $clog2(N_QUAD),
    localparam int POS_W  = (N_SPARE > 1) ? $clog2(N_SPARE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [QUAD_W-1:0] wr_quad,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [QUAD_W-1:0] lk_quad,
    input  logic [IDX_W-1:0]  lk_addr,
    output logic              lk_hit,
    output logic [POS_W-1:0]  lk_pos,
    output logic              wr_dup
);
    logic [IDX_W-1:0] idx_q   [N_QUAD][N_SPARE];
    logic             valid_q [N_QUAD][N_SPARE];
    logic [N_SPARE-1:0] match_vec;
    logic [N_SPARE-1:0] dup_vec;
    logic               slot_ok;

    assign slot_ok = (32'(wr_slot) < N_SPARE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < N_QUAD; q++) begin
                for (int s = 0; s < N_SPARE; s++) begin
                    idx_q[q][s]   <= '0;
                    valid_q[q][s] <= 1'b0;
                end
            end
        end else if (wr_en) begin
            for (int q = 0; q < N_QUAD; q++) begin
                for (int s = 0; s < N_SPARE; s++) begin
                    if (32'(wr_quad) == q && 32'(wr_slot) == s) begin
                        idx_q[q][s]   <= wr_index;
                        valid_q[q][s] <= wr_valid;
                    end
                end
            end
        end
    end

    for (genvar s = 0; s < N_SPARE; s++) begin : g_cmp
        assign match_vec[s] = valid_q[lk_quad][s] && (idx_q[lk_quad][s] == lk_addr);
        assign dup_vec[s]   = valid_q[wr_quad][s] && (idx_q[wr_quad][s] == wr_index)
                              && (32'(wr_slot) != s);
    end

    assign wr_dup = wr_en && wr_valid && slot_ok && (|dup_vec);

    rr_first_set #(.N(N_SPARE), .OUT_W(POS_W)) u_pick (
        .req (match_vec),
        .any (lk_hit),
        .pos (lk_pos)
    );
endmodule

// File: rtl/rr_repair_remap.sv
module rr_repair_remap
    import rr_repair_pkg::*;
#(
    parameter int N_QUAD     = 4,
    parameter int ROW_W      = 8,
    parameter int COL_W      = 8,
    parameter int ROW_SPARES = 16,
    parameter int COL_SPARES = 24,
    localparam int QUAD_W    = $clog2(N_QUAD),
    localparam int RPOS_W    = $clog2(ROW_SPARES),
    localparam int CPOS_W    = $clog2(COL_SPARES),
    localparam int SLOT_W    = (RPOS_W > CPOS_W) ? RPOS_W : CPOS_W,
    localparam int IDX_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QUAD_W-1:0] cfg_quad,
    input  logic              cfg_kind,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_valid,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [QUAD_W-1:0] acc_quad,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic [COL_W-1:0]  acc_col,
    output logic [ROW_W-1:0]  phys_row,
    output logic              row_on_spare,
    output logic [COL_W-1:0]  phys_col,
    output logic              col_on_spare,
    output logic              cfg_error
);
    logic              row_hit, col_hit, row_dup, col_dup;
    logic [RPOS_W-1:0] row_pos;
    logic [CPOS_W-1:0] col_pos;
    cfg_state_t        state_q, state_d;

    rr_spare_bank #(
        .N_QUAD(N_QUAD), .N_SPARE(ROW_SPARES), .IDX_W(ROW_W), .SLOT_W(SLOT_W)
    ) u_rows (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_kind == KIND_ROW),
        .wr_quad(cfg_quad), .wr_slot(cfg_slot), .wr_valid(cfg_valid),
        .wr_index(cfg_index[ROW_W-1:0]),
        .lk_quad(acc_quad), .lk_addr(acc_row),
        .lk_hit(row_hit), .lk_pos(row_pos), .wr_dup(row_dup)
    );

    rr_spare_bank #(
        .N_QUAD(N_QUAD), .N_SPARE(COL_SPARES), .IDX_W(COL_W), .SLOT_W(SLOT_W)
    ) u_cols (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_kind == KIND_COL),
        .wr_quad(cfg_quad), .wr_slot(cfg_slot), .wr_valid(cfg_valid),
        .wr_index(cfg_index[COL_W-1:0]),
        .lk_quad(acc_quad), .lk_addr(acc_col),
        .lk_hit(col_hit), .lk_pos(col_pos), .wr_dup(col_dup)
    );

    // Configuration monitor: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_CLEAN;
        else        state_q <= state_d;
    end

    // Configuration monitor: next state and output
    always_comb begin
        state_d   = state_q;
        cfg_error = 1'b0;
        unique case (state_q)
            CFG_CLEAN: if (row_dup || col_dup) state_d = CFG_FAULT;
            CFG_FAULT: begin
                state_d   = CFG_FAULT;
                cfg_error = 1'b1;
            end
        endcase
    end

    // Address steering
    always_comb begin
        phys_row     = acc_row;
        row_on_spare = row_hit;
        if (row_hit) begin
            phys_row             = '0;
            phys_row[RPOS_W-1:0] = row_pos;
        end
        phys_col     = acc_col;
        col_on_spare = col_hit;
        if (col_hit) begin
            phys_col             = '0;
            phys_col[CPOS_W-1:0] = col_pos;
        end
    end
endmodule

// File: rtl/rr_repair_remap_chk.sv
module rr_repair_remap_chk #(
    parameter int ROW_W      = 8,
    parameter int COL_W      = 8,
    parameter int ROW_SPARES = 16,
    parameter int COL_SPARES = 24,
    parameter int SLOT_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_kind,
    input logic [SLOT_W-1:0] cfg_slot,
    input logic              cfg_error,
    input logic [ROW_W-1:0]  acc_row,
    input logic [COL_W-1:0]  acc_col,
    input logic [ROW_W-1:0]  phys_row,
    input logic              row_on_spare,
    input logic [COL_W-1:0]  phys_col,
    input logic              col_on_spare
);
    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_on_spare |-> phys_row == acc_row) and (!col_on_spare |-> phys_col == acc_col));

    // R2
    row_spare_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_on_spare |-> 32'(phys_row) < ROW_SPARES);

    // R3
    col_spare_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_on_spare |-> 32'(phys_col) < COL_SPARES);

    // R8
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error);

    // R10
    bad_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == 1'b0 && 32'(cfg_slot) >= ROW_SPARES && !cfg_error) |=> !cfg_error);
endmodule

bind rr_repair_remap rr_repair_remap_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ROW_SPARES(ROW_SPARES),
    .COL_SPARES(COL_SPARES), .SLOT_W(SLOT_W)
) u_chk (.*);

// File: tb/rr_repair_remap_tb_top.sv
`timescale 1ns/1ps
module rr_repair_remap_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_kind = 1'b0, cfg_valid = 1'b0;
    logic [1:0] cfg_quad = '0, acc_quad = '0;
    logic [4:0] cfg_slot = '0;
    logic [7:0] cfg_index = '0, acc_row = '0, acc_col = '0;
    logic [7:0] phys_row, phys_col;
    logic       row_on_spare, col_on_spare, cfg_error;

    int    n_checks = 0, n_fail = 0;
    string phase = "R1";
    bit    cmp_on = 1'b0;

    int mr_idx [4][16]; bit mr_v [4][16];
    int mc_idx [4][24]; bit mc_v [4][24];
    bit m_err;

    always #10 clk = ~clk;

    rr_repair_remap dut_i (.*);

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find_row(int q, int a);
        for (int s = 0; s < 16; s++) if (mr_v[q][s] && mr_idx[q][s] == a) return s;
        return -1;
    endfunction

    function automatic int find_col(int q, int a);
        for (int s = 0; s < 24; s++) if (mc_v[q][s] && mc_idx[q][s] == a) return s;
        return -1;
    endfunction

    task automatic compare_all(string tag);
        int rs, cs;
        rs = find_row(int'(acc_quad), int'(acc_row));
        cs = find_col(int'(acc_quad), int'(acc_col));
        check(tag, "row_on_spare", int'(row_on_spare), int'(rs >= 0));
        check(tag, "phys_row", int'(phys_row), (rs >= 0) ? rs : int'(acc_row));
        check(tag, "col_on_spare", int'(col_on_spare), int'(cs >= 0));
        check(tag, "phys_col", int'(phys_col), (cs >= 0) ? cs : int'(acc_col));
        check(tag, "cfg_error", int'(cfg_error), int'(m_err));
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) if (cmp_on && rst_n) compare_all(phase);

    task automatic model_reset();
        for (int q = 0; q < 4; q++) begin
            for (int s = 0; s < 16; s++) begin mr_v[q][s] = 0; mr_idx[q][s] = 0; end
            for (int s = 0; s < 24; s++) begin mc_v[q][s] = 0; mc_idx[q][s] = 0; end
        end
        m_err = 0;
    endtask

    task automatic wr(int q, int kind, int slot, int valid, int idx);
        @(posedge clk); #1;
        cfg_we = 1; cfg_quad = 2'(q); cfg_kind = 1'(kind); cfg_slot = 5'(slot);
        cfg_valid = 1'(valid); cfg_index = 8'(idx);
        @(posedge clk); #1;
        cfg_we = 0;
        if (kind == 0 && slot < 16) begin
            for (int j = 0; j < 16; j++)
                if (valid != 0 && j != slot && mr_v[q][j] && mr_idx[q][j] == idx) m_err = 1;
            mr_v[q][slot] = (valid != 0); mr_idx[q][slot] = idx;
        end else if (kind == 1 && slot < 24) begin
            for (int j = 0; j < 24; j++)
                if (valid != 0 && j != slot && mc_v[q][j] && mc_idx[q][j] == idx) m_err = 1;
            mc_v[q][slot] = (valid != 0); mc_idx[q][slot] = idx;
        end
    endtask

    task automatic access(int q, int r, int c);
        @(posedge clk); #1;
        acc_quad = 2'(q); acc_row = 8'(r); acc_col = 8'(c);
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        #(20.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        cmp_on = 1;
        // R1: empty table passes addresses through
        phase = "R1";
        access(0, 8'h12, 8'h40);
        access(3, 8'hFF, 8'h00);
        check("R1", "cfg_error after reset", int'(cfg_error), 0);

        // R2: row repair
        phase = "R2";
        wr(0, 0, 3, 1, 8'h12);
        access(0, 8'h12, 8'h41);
        check("R2", "phys_row", int'(phys_row), 3);
        // R3 and R4: column repair, then both together
        phase = "R3";
        wr(0, 1, 20, 1, 8'h40);
        access(0, 8'h13, 8'h40);
        check("R3", "phys_col", int'(phys_col), 20);
        phase = "R4";
        access(0, 8'h12, 8'h40);
        check("R4", "both spares", int'({row_on_spare, col_on_spare}), 3);

        // R5: other quadrant not affected
        phase = "R5";
        access(1, 8'h12, 8'h40);
        check("R5", "row_on_spare q1", int'(row_on_spare), 0);

        // R6: clear the row entry
        phase = "R6";
        wr(0, 0, 3, 0, 8'h12);
        access(0, 8'h12, 8'h40);
        check("R6", "cleared slot", int'(row_on_spare), 0);

        // R12: identical rewrite is not a duplicate
        phase = "R12";
        wr(2, 0, 5, 1, 8'h33);
        wr(2, 0, 5, 1, 8'h33);
        check("R12", "cfg_error", int'(cfg_error), 0);

        // R10: out-of-range slots are ignored
        phase = "R10";
        wr(2, 0, 20, 1, 8'h33);
        wr(2, 1, 28, 1, 8'h77);
        access(2, 8'h77, 8'h77);
        check("R10", "cfg_error", int'(cfg_error), 0);
        check("R10", "col_on_spare", int'(col_on_spare), 0);

        // R11: fill quadrant 3 completely
        phase = "R11";
        for (int s = 0; s < 16; s++) wr(3, 0, s, 1, 8'h80 + s);
        for (int s = 0; s < 24; s++) wr(3, 1, s, 1, 8'h10 + s);
        for (int s = 0; s < 24; s++) begin
            access(3, 8'h80 + (s % 16), 8'h10 + s);
            check("R11", "phys_col", int'(phys_col), s);
            check("R11", "phys_row", int'(phys_row), s % 16);
        end

        // R7: combinational response inside one cycle
        phase = "R7";
        @(posedge clk); #1;
        acc_quad = 3; acc_row = 8'h85; acc_col = 8'h00;
        #4;
        acc_row = 8'h8A; acc_col = 8'h12;
        #2;
        check("R7", "phys_row", int'(phys_row), 10);
        check("R7", "phys_col", int'(phys_col), 2);
        @(negedge clk); #1;

        // R8 and R9: duplicate entry, lower slot wins, flag sticks
        phase = "R9";
        wr(2, 0, 2, 1, 8'h33);
        access(2, 8'h33, 8'h00);
        check("R9", "lowest slot", int'(phys_row), 2);
        phase = "R8";
        check("R8", "cfg_error set", int'(cfg_error), 1);
        wr(1, 1, 0, 1, 8'h01);
        repeat (3) access(1, 0, 1);
        check("R8", "cfg_error sticky", int'(cfg_error), 1);

        // R1: reset clears the flag and the table
        cmp_on = 0;
        phase = "R1";
        do_reset();
        cmp_on = 1;
        access(3, 8'h85, 8'h12);
        check("R1", "cfg_error cleared", int'(cfg_error), 0);
        check("R1", "table cleared", int'(row_on_spare), 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule